// File: doc/BRIEF.md
# Banked PWM Channel Register File

This block is the host-facing register store for a group of PWM channels. A byte-wide synchronous bus (address, write data, write strobe, combinational read data) reaches a fixed window of seven control bytes. A bank-select register decides which channel's private copy of those seven bytes the window reads and writes. Every channel's full set of control bytes is driven out in parallel to the channel datapaths, together with a per-channel enable mask.

Writing control byte 0 of a bank is treated as the final step of configuring that bank. That write raises a one-cycle load pulse for the bank, and the channel datapath acts on any start bits at that moment. The duty lookup table lives outside the block. It is loaded through two bytes: a low byte that is only held, and a high byte that carries value bit 8, a read-request flag and the table index, and that issues the table write strobe. A test register routes the PWM output of one chosen channel to a single digital test pin.

Top module: `pwmbank_regs`

## Requirements
- R1: After reset, every control byte of every bank, the bank select, the enable mask, both table bytes and the test register are zero, and no load pulse or table write strobe is active.
- R2: A write to window address k (0 to 6) changes control byte k of the currently selected bank only. On `ctrlBytes`, byte k of bank b sits at bits [(b*7+k)*8 +: 8].
- R3: A read of window address k returns control byte k of the currently selected bank. Changing the select value changes which copy is read.
- R4: Address 7 is the bank select, and it stores write-data bits 2:0. Upper write-data bits are ignored and read back as zero.
- R5: Address 8 holds the enable mask. Bit n of the stored byte drives `bankEn[n]`, and the byte reads back unchanged.
- R6: A write to window address 0 raises `cfgLoad[b]` for the selected bank b during exactly the cycle after the write edge. Writes to window addresses 1 to 6 raise no load pulse.
- R7: Address 9 stores the table low byte. A write to address 10 with bit 6 clear raises `lutWrEn` during the following cycle, with `lutWrIdx` = bits 5:0 of that byte and `lutWrVal` = {bit 7 of that byte, most recent low byte}.
- R8: A write to address 10 with bit 6 (read request) set is stored, but it raises no table write strobe.
- R9: Address 11 holds the test bank in bits 2:0 and the test mode in bits 5:3. When the mode is 1, `testOut` follows `chanPwm` of that bank. For any other mode, `testOut` is 0.
- R10: Addresses 12 to 15 read as zero. Writes to them change no stored state and no output.
- R11: Addresses 9, 10 and 11 read back the stored bytes. Bits 7:6 of the test register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| we | input | 1 | Write strobe, sampled on the rising edge |
| rdData | output | 8 | Combinational read data for `addr` |
| chanPwm | input | 8 | PWM outputs of the channels, used for test routing |
| ctrlBytes | output | 448 | All banks' control bytes, flattened |
| bankEn | output | 8 | Per-channel enable mask |
| cfgLoad | output | 8 | One-cycle per-bank load pulse on a byte-0 write |
| lutWrEn | output | 1 | Table write strobe |
| lutWrIdx | output | 6 | Table write index |
| lutWrVal | output | 9 | Table write value |
| testOut | output | 1 | Routed test output |

## Verification
The hardest case is showing that a window write lands in one bank only. From the bus, just one bank is visible at a time. The bench therefore fills all 56 control bytes with distinct values, each reached by reselecting before it is written. It then compares every byte of the flattened `ctrlBytes` output against its own model, and re-reads each bank through the window after reselecting it. The test routing is swept over every mode and bank with two complementary channel patterns, so a wrong bank decode or mode decode shows up as a mismatch.

// File: rtl/pwmbank_pkg.sv
package pwmbank_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int CTRL_BYTES = 7;
  localparam int WIN_W      = $clog2(CTRL_BYTES);

  localparam logic [ADDR_W-1:0] ADDR_SEL  = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_TLO  = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_THI  = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_TEST = 4'd11;

  localparam int THI_REQ_BIT = 6;
  localparam int THI_V8_BIT  = 7;
  localparam logic [2:0] TEST_MODE_ROUTE = 3'd1;

  typedef enum logic [2:0] {
    RD_NONE, RD_WIN, RD_SEL, RD_EN, RD_TLO, RD_THI, RD_TEST
  } rdSrc_e;

  typedef struct packed {
    logic       winWr;
    logic       selWr;
    logic       enWr;
    logic       tloWr;
    logic       thiWr;
    logic       testWr;
    rdSrc_e     rdSrc;
    logic [WIN_W-1:0] winIdx;
  } strobes_t;
endpackage

// File: rtl/pwmbank_ctrl.sv
module pwmbank_ctrl
  import pwmbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output strobes_t          strb
);
  always_comb begin
    strb = '0;
    strb.rdSrc = RD_NONE;
    strb.winIdx = addr[WIN_W-1:0];
    if (addr < ADDR_W'(CTRL_BYTES)) begin
      strb.rdSrc = RD_WIN;
      strb.winWr = we;
    end else begin
      unique case (addr)
        ADDR_SEL:  begin strb.rdSrc = RD_SEL;  strb.selWr  = we; end
        ADDR_EN:   begin strb.rdSrc = RD_EN;   strb.enWr   = we; end
        ADDR_TLO:  begin strb.rdSrc = RD_TLO;  strb.tloWr  = we; end
        ADDR_THI:  begin strb.rdSrc = RD_THI;  strb.thiWr  = we; end
        ADDR_TEST: begin strb.rdSrc = RD_TEST; strb.testWr = we; end
        default:   strb.rdSrc = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pwmbank_dp.sv
module pwmbank_dp
  import pwmbank_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int LUT_IDX_W = 6
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  strobes_t                             strb,
  input  logic [DATA_W-1:0]                    wrData,
  input  logic [NUM_BANKS-1:0]                 chanPwm,
  output logic [DATA_W-1:0]                    rdData,
  output logic [NUM_BANKS*CTRL_BYTES*DATA_W-1:0] ctrlBytes,
  output logic [NUM_BANKS-1:0]                 bankEn,
  output logic [NUM_BANKS-1:0]                 cfgLoad,
  output logic                                 lutWrEn,
  output logic [LUT_IDX_W-1:0]                 lutWrIdx,
  output logic [DATA_W:0]                      lutWrVal,
  output logic                                 testOut
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [DATA_W-1:0] ctrlMem [NUM_BANKS][CTRL_BYTES];
  logic [BANK_W-1:0] selReg;
  logic [DATA_W-1:0] tloReg, thiReg;
  logic [5:0]        testReg;
  logic [2:0]        testMode;
  logic [BANK_W-1:0] testBank;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar k = 0; k < CTRL_BYTES; k++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) ctrlMem[b][k] <= '0;
        else if (strb.winWr && selReg == BANK_W'(b) && strb.winIdx == WIN_W'(k))
          ctrlMem[b][k] <= wrData;
      end
      assign ctrlBytes[(b*CTRL_BYTES+k)*DATA_W +: DATA_W] = ctrlMem[b][k];
    end
    always_ff @(posedge clk) begin
      if (rst) cfgLoad[b] <= 1'b0;
      else cfgLoad[b] <= strb.winWr && strb.winIdx == '0 && selReg == BANK_W'(b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg   <= '0;
      bankEn   <= '0;
      tloReg   <= '0;
      thiReg   <= '0;
      testReg  <= '0;
      lutWrEn  <= 1'b0;
      lutWrIdx <= '0;
      lutWrVal <= '0;
    end else begin
      lutWrEn <= 1'b0;
      if (strb.selWr)  selReg  <= wrData[BANK_W-1:0];
      if (strb.enWr)   bankEn  <= wrData[NUM_BANKS-1:0];
      if (strb.tloWr)  tloReg  <= wrData;
      if (strb.testWr) testReg <= wrData[5:0];
      if (strb.thiWr) begin
        thiReg <= wrData;
        if (!wrData[THI_REQ_BIT]) begin
          lutWrEn  <= 1'b1;
          lutWrIdx <= wrData[LUT_IDX_W-1:0];
          lutWrVal <= {wrData[THI_V8_BIT], tloReg};
        end
      end
    end
  end

  assign testMode = testReg[5:3];
  assign testBank = testReg[BANK_W-1:0];
  assign testOut  = (testMode == TEST_MODE_ROUTE) ? chanPwm[testBank] : 1'b0;

  always_comb begin
    unique case (strb.rdSrc)
      RD_WIN:  rdData = ctrlMem[selReg][strb.winIdx];
      RD_SEL:  rdData = DATA_W'(selReg);
      RD_EN:   rdData = DATA_W'(bankEn);
      RD_TLO:  rdData = tloReg;
      RD_THI:  rdData = thiReg;
      RD_TEST: rdData = DATA_W'(testReg);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwmbank_regs.sv
module pwmbank_regs
  import pwmbank_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int LUT_IDX_W = 6
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [DATA_W-1:0]                      wrData,
  input  logic                                   we,
  output logic [DATA_W-1:0]                      rdData,
  input  logic [NUM_BANKS-1:0]                   chanPwm,
  output logic [NUM_BANKS*CTRL_BYTES*DATA_W-1:0] ctrlBytes,
  output logic [NUM_BANKS-1:0]                   bankEn,
  output logic [NUM_BANKS-1:0]                   cfgLoad,
  output logic                                   lutWrEn,
  output logic [LUT_IDX_W-1:0]                   lutWrIdx,
  output logic [DATA_W:0]                        lutWrVal,
  output logic                                   testOut
);
  strobes_t strb;

  pwmbank_ctrl u_ctrl (.addr(addr), .we(we), .strb(strb));

  pwmbank_dp #(.NUM_BANKS(NUM_BANKS), .LUT_IDX_W(LUT_IDX_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .chanPwm(chanPwm),
    .rdData(rdData), .ctrlBytes(ctrlBytes), .bankEn(bankEn), .cfgLoad(cfgLoad),
    .lutWrEn(lutWrEn), .lutWrIdx(lutWrIdx), .lutWrVal(lutWrVal), .testOut(testOut)
  );
endmodule

// File: rtl/pwmbank_chk.sv
module pwmbank_chk
  import pwmbank_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic                 we,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_BANKS-1:0] bankEn,
  input logic [NUM_BANKS-1:0] cfgLoad,
  input logic                 lutWrEn
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  p_single_load_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cfgLoad));
  p_load_source_r6: assert property (@(posedge clk) disable iff (rst)
    (|cfgLoad) |-> $past(we && addr == '0));
  p_commit_source_r7: assert property (@(posedge clk) disable iff (rst)
    lutWrEn |-> $past(we && addr == ADDR_THI && !wrData[THI_REQ_BIT]));
  p_req_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_THI && wrData[THI_REQ_BIT]) |=> !lutWrEn);
  p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == ADDR_EN) |=> $stable(bankEn));
  p_sel_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_SEL) |-> (rdData[DATA_W-1:BANK_W] == '0));
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (addr > ADDR_TEST) |-> (rdData == '0));
endmodule

bind pwmbank_regs pwmbank_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .we(we), .rdData(rdData),
  .bankEn(bankEn), .cfgLoad(cfgLoad), .lutWrEn(lutWrEn)
);

// File: tb/test_pwmbank_regs.sv
`timescale 1ns/1ps
module test_pwmbank_regs;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   addr = '0;
  logic [7:0]   wrData = '0;
  logic         we = 1'b0;
  logic [7:0]   rdData;
  logic [7:0]   chanPwm = '0;
  logic [447:0] ctrlBytes;
  logic [7:0]   bankEn, cfgLoad;
  logic         lutWrEn;
  logic [5:0]   lutWrIdx;
  logic [8:0]   lutWrVal;
  logic         testOut;

  int total = 0;
  int bad = 0;
  logic [7:0] model [8][7];

  always #5 clk = ~clk;

  pwmbank_regs i_pwmbank_regs (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .we(we), .rdData(rdData),
    .chanPwm(chanPwm), .ctrlBytes(ctrlBytes), .bankEn(bankEn), .cfgLoad(cfgLoad),
    .lutWrEn(lutWrEn), .lutWrIdx(lutWrIdx), .lutWrVal(lutWrVal), .testOut(testOut)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; #1;
    chk(rdData === exp, req, 64'(rdData), 64'(exp));
  endtask

  task automatic cmp_all(input string req);
    for (int b = 0; b < 8; b++)
      for (int k = 0; k < 7; k++)
        chk(ctrlBytes[(b*7+k)*8 +: 8] === model[b][k], req,
            64'(ctrlBytes[(b*7+k)*8 +: 8]), 64'(model[b][k]));
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) for (int k = 0; k < 7; k++) model[b][k] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk(bankEn === 8'h0, "R1 bankEn", 64'(bankEn), 0);
    chk(cfgLoad === 8'h0, "R1 cfgLoad", 64'(cfgLoad), 0);
    chk(lutWrEn === 1'b0, "R1 lutWrEn", 64'(lutWrEn), 0);
    cmp_all("R1 ctrlBytes");
    for (int a = 0; a < 16; a++) rdchk(4'(a), 8'h00, "R1 read");

    // R2 R3 R4 R6 fill every bank
    for (int b = 0; b < 8; b++) begin
      wr(4'd7, {5'b10110, 3'(b)});
      rdchk(4'd7, 8'(b), "R4 select readback");
      for (int k = 0; k < 7; k++) begin
        logic [7:0] v;
        v = 8'(b*37 + k*11 + 5);
        wr(4'(k), v);
        model[b][k] = v;
        chk(cfgLoad === ((k == 0) ? 8'(1 << b) : 8'h00), "R6 load pulse",
            64'(cfgLoad), 64'((k == 0) ? (1 << b) : 0));
        @(posedge clk); #1;
        chk(cfgLoad === 8'h00, "R6 pulse one cycle", 64'(cfgLoad), 0);
      end
    end
    cmp_all("R2 bank isolation");
    for (int b = 7; b >= 0; b--) begin
      wr(4'd7, 8'(b));
      for (int k = 0; k < 7; k++) rdchk(4'(k), model[b][k], "R3 window read");
    end

    // R5 enable mask
    foreach (model[i]) begin
      logic [7:0] p;
      p = 8'(8'h5A ^ (i * 8'h13));
      wr(4'd8, p);
      chk(bankEn === p, "R5 bankEn", 64'(bankEn), 64'(p));
      rdchk(4'd8, p, "R5 readback");
    end

    // R7 R8 R11 table loading
    for (int idx = 0; idx < 64; idx += 3) begin
      logic [7:0] lo, hi;
      lo = 8'(idx*5 + 1);
      hi = {idx[0], 1'b0, 6'(idx)};
      wr(4'd9, lo);
      wr(4'd10, hi);
      chk(lutWrEn === 1'b1, "R7 strobe", 64'(lutWrEn), 1);
      chk(lutWrIdx === 6'(idx), "R7 index", 64'(lutWrIdx), 64'(idx));
      chk(lutWrVal === {idx[0], lo}, "R7 value", 64'(lutWrVal), 64'({idx[0], lo}));
      @(posedge clk); #1;
      chk(lutWrEn === 1'b0, "R7 strobe one cycle", 64'(lutWrEn), 0);
      rdchk(4'd9, lo, "R11 low readback");
      rdchk(4'd10, hi, "R11 high readback");
      wr(4'd10, hi | 8'h40);
      chk(lutWrEn === 1'b0, "R8 read request no commit", 64'(lutWrEn), 0);
      rdchk(4'd10, hi | 8'h40, "R8 stored");
    end

    // R9 R11 test routing
    for (int m = 0; m < 8; m++)
      for (int b = 0; b < 8; b++) begin
        wr(4'd11, {2'b11, 3'(m), 3'(b)});
        rdchk(4'd11, {2'b00, 3'(m), 3'(b)}, "R11 test readback");
        for (int pat = 0; pat < 2; pat++) begin
          logic e;
          chanPwm = pat ? 8'h5A : 8'hA5;
          #1;
          e = (m == 1) ? chanPwm[b] : 1'b0;
          chk(testOut === e, "R9 testOut", 64'(testOut), 64'(e));
        end
      end

    // R10 unused addresses
    wr(4'd11, 8'h00);
    for (int a = 12; a < 16; a++) wr(4'(a), 8'hFF);
    cmp_all("R10 ctrl untouched");
    chk(bankEn === 8'(8'h5A ^ (7 * 8'h13)), "R10 bankEn untouched", 64'(bankEn),
        64'(8'(8'h5A ^ (7 * 8'h13))));
    rdchk(4'd11, 8'h00, "R10 test untouched");
    for (int a = 12; a < 16; a++) rdchk(4'(a), 8'h00, "R10 read zero");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule